// File: doc/BRIEF.md
# Consensus Request Sequencer

This stage sits in a header-processing pipeline and acts as the ordering point of a consensus protocol. Parsed message headers arrive on a valid/ready interface. When a header carries the client-request type code, the stage stamps it with the next instance number and sets its round to zero. It relabels the message as an accept request and raises a flag that tells the downstream replication logic to send it to every acceptor. The stage never creates a message of its own. It only edits fields of the message it is holding.

A single persistent instance counter supplies the stamps. A control port can reload the counter when the ordering role moves to this device, or when the block of pre-computed instances has been used up. An output flag warns when the counter is within a programmable distance of the configured instance limit. Headers of any other type are either forwarded untouched or silently consumed, according to a configuration bit.

Top module: `req_sequencer`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and the instance counter is zero, so the first request stamped gets instance 0.
- R2: A header is taken when in_valid and in_ready are both high, and its result appears on the outputs in the next cycle. While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low.
- R3: A request (type code 0) leaves with type code 3 (accept request), round 0, instance equal to the counter, out_bcast high, and voted round, sender and value unchanged.
- R4: Requests taken in consecutive handshakes get consecutive instance numbers, with no gap and no repeat.
- R5: When ld_en is high, the counter takes ld_val. If a request is taken in the same cycle, that request is stamped with ld_val and the next request gets ld_val+1.
- R6: The counter wraps from all ones to zero at the configured instance width.
- R7: With cfg_drop_other low, a header of any non-request type leaves with every field unchanged and out_bcast low, and the counter does not advance.
- R8: With cfg_drop_other high, a header of any non-request type is taken, produces no output, and does not advance the counter.
- R9: near_limit is high when the counter is at or above cfg_limit, or when cfg_limit minus the counter is at most cfg_margin. Otherwise it is low.
- R10: The type code is compared on all eight bits. For example, code 0x80 is not a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_drop_other | input | 1 | 1: consume non-request headers; 0: forward them unchanged |
| cfg_limit | input | IW | Last pre-computed instance number |
| cfg_margin | input | IW | Warning distance below cfg_limit |
| ld_en | input | 1 | Reload the instance counter |
| ld_val | input | IW | Counter reload value |
| in_valid | input | 1 | Input header present |
| in_ready | output | 1 | Stage can take a header |
| in_type | input | 8 | Message type code |
| in_inst | input | IW | Instance number |
| in_rnd | input | 8 | Round |
| in_vrnd | input | 8 | Voted round |
| in_sender | input | 64 | Sender identifier |
| in_value | input | VW | Value |
| out_valid | output | 1 | Output header present |
| out_ready | input | 1 | Downstream takes the header |
| out_type | output | 8 | Message type code |
| out_inst | output | IW | Instance number |
| out_rnd | output | 8 | Round |
| out_vrnd | output | 8 | Voted round |
| out_sender | output | 64 | Sender identifier |
| out_value | output | VW | Value |
| out_bcast | output | 1 | Send to all acceptors |
| near_limit | output | 1 | Counter is close to or past cfg_limit |

## Verification
A counter reload and a request can be taken in the same cycle. This collision decides which instance number the request receives. The bench provokes it by raising ld_en together with a request handshake. It then checks that this request carries the loaded value and that the following request carries that value plus one. A second overlap comes from backpressure: a request stays pending while the output is stalled. The bench checks that the stalled request is not stamped until the stall ends, and that it then receives the very next number.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    localparam int TYPE_W   = 8;
    localparam int RND_W    = 8;
    localparam int SENDER_W = 64;

    localparam logic [TYPE_W-1:0] MT_REQUEST = 8'd0;
    localparam logic [TYPE_W-1:0] MT_PREP    = 8'd1;
    localparam logic [TYPE_W-1:0] MT_PROMISE = 8'd2;
    localparam logic [TYPE_W-1:0] MT_ACCEPT  = 8'd3;
    localparam logic [TYPE_W-1:0] MT_VOTE    = 8'd4;

    typedef enum logic [1:0] {
        ACT_SEQ  = 2'd0,
        ACT_PASS = 2'd1,
        ACT_DROP = 2'd2
    } act_e;

    function automatic act_e pick_action(
        input logic [TYPE_W-1:0] code,
        input logic [TYPE_W-1:0] req_code,
        input logic              drop_other
    );
        if (code == req_code) return ACT_SEQ;
        else if (drop_other)  return ACT_DROP;
        else                  return ACT_PASS;
    endfunction

endpackage

// File: rtl/cseq_classify.sv
module cseq_classify
    import cseq_pkg::*;
#(
    parameter logic [TYPE_W-1:0] REQ_CODE = MT_REQUEST
) (
    input  logic [TYPE_W-1:0] msg_type,
    input  logic              drop_other,
    output act_e              act
);
    always_comb begin
        act = pick_action(msg_type, REQ_CODE, drop_other);
    end
endmodule

// File: rtl/cseq_counter.sv
module cseq_counter #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_val,
    input  logic          bump,
    input  logic [IW-1:0] limit,
    input  logic [IW-1:0] margin,
    output logic [IW-1:0] stamp,
    output logic          near
);
    logic [IW-1:0] cnt_q;
    logic [IW-1:0] headroom;

    // a reload wins over the stored value in the same cycle
    always_comb begin
        stamp = ld_en ? ld_val : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (bump)      cnt_q <= stamp + 1'b1;
        else if (ld_en)     cnt_q <= ld_val;
    end

    always_comb begin
        headroom = limit - cnt_q;
        near     = (cnt_q >= limit) || (headroom <= margin);
    end
endmodule

// File: rtl/cseq_stage.sv
module cseq_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    input  logic         d_bcast,
    input  logic         take,
    output logic         valid,
    output logic [W-1:0] q,
    output logic         q_bcast,
    output logic         free
);
    always_comb begin
        free = !valid || take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            q       <= '0;
            q_bcast <= 1'b0;
        end else if (free) begin
            valid <= load;
            if (load) begin
                q       <= d;
                q_bcast <= d_bcast;
            end
        end
    end
endmodule

// File: rtl/req_sequencer.sv
module req_sequencer
    import cseq_pkg::*;
#(
    parameter int IW = 16,
    parameter int VW = 64,
    parameter logic [7:0] REQ_CODE = MT_REQUEST,
    parameter logic [7:0] ACC_CODE = MT_ACCEPT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_drop_other,
    input  logic [IW-1:0] cfg_limit,
    input  logic [IW-1:0] cfg_margin,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_val,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_type,
    input  logic [IW-1:0] in_inst,
    input  logic [7:0]    in_rnd,
    input  logic [7:0]    in_vrnd,
    input  logic [63:0]   in_sender,
    input  logic [VW-1:0] in_value,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_type,
    output logic [IW-1:0] out_inst,
    output logic [7:0]    out_rnd,
    output logic [7:0]    out_vrnd,
    output logic [63:0]   out_sender,
    output logic [VW-1:0] out_value,
    output logic          out_bcast,
    output logic          near_limit
);
    localparam int HW = TYPE_W + IW + RND_W + RND_W + SENDER_W + VW;

    act_e          act;
    logic          fire;
    logic          seq_now;
    logic [IW-1:0] stamp;
    logic [HW-1:0] hdr_new;
    logic [HW-1:0] hdr_q;
    logic          stage_free;

    cseq_classify #(.REQ_CODE(REQ_CODE)) u_cls (
        .msg_type   (in_type),
        .drop_other (cfg_drop_other),
        .act        (act)
    );

    always_comb begin
        fire    = in_valid && stage_free;
        seq_now = fire && (act == ACT_SEQ);
    end

    cseq_counter #(.IW(IW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .bump   (seq_now),
        .limit  (cfg_limit),
        .margin (cfg_margin),
        .stamp  (stamp),
        .near   (near_limit)
    );

    // rewrite in flight: only type, instance and round change on a request
    always_comb begin
        if (act == ACT_SEQ)
            hdr_new = {ACC_CODE, stamp, 8'd0, in_vrnd, in_sender, in_value};
        else
            hdr_new = {in_type, in_inst, in_rnd, in_vrnd, in_sender, in_value};
    end

    cseq_stage #(.W(HW)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid && (act != ACT_DROP)),
        .d       (hdr_new),
        .d_bcast (act == ACT_SEQ),
        .take    (out_ready),
        .valid   (out_valid),
        .q       (hdr_q),
        .q_bcast (out_bcast),
        .free    (stage_free)
    );

    always_comb begin
        in_ready = stage_free;
        {out_type, out_inst, out_rnd, out_vrnd, out_sender, out_value} = hdr_q;
    end
endmodule

// File: rtl/req_sequencer_chk.sv
module req_sequencer_chk #(
    parameter int IW = 16,
    parameter logic [7:0] REQ_CODE = 8'd0,
    parameter logic [7:0] ACC_CODE = 8'd3
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_drop_other,
    input logic          ld_en,
    input logic [IW-1:0] ld_val,
    input logic          in_valid,
    input logic          in_ready,
    input logic [7:0]    in_type,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_type,
    input logic [IW-1:0] out_inst,
    input logic [7:0]    out_rnd,
    input logic          out_bcast
);
    logic acc_req;
    logic acc_oth;
    always_comb begin
        acc_req = in_valid && in_ready && (in_type == REQ_CODE);
        acc_oth = in_valid && in_ready && (in_type != REQ_CODE);
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_inst) && $stable(out_type)); // R2

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> out_valid && out_bcast); // R2

    AST_SEQ_FIELDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_bcast |-> out_type == ACC_CODE && out_rnd == 8'd0); // R3

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !ld_en) ##1 (acc_req && !ld_en) |=> out_inst == IW'($past(out_inst) + 1'b1)); // R4

    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        acc_req && ld_en |=> out_inst == $past(ld_val)); // R5

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        acc_oth && cfg_drop_other |=> !out_valid); // R8

    AST_PASS_PLAIN: assert property (@(posedge clk) disable iff (rst)
        acc_oth && !cfg_drop_other |=> out_valid && !out_bcast); // R7
endmodule

bind req_sequencer req_sequencer_chk #(.IW(IW), .REQ_CODE(REQ_CODE), .ACC_CODE(ACC_CODE)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_drop_other (cfg_drop_other),
    .ld_en          (ld_en),
    .ld_val         (ld_val),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_type        (in_type),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_type       (out_type),
    .out_inst       (out_inst),
    .out_rnd        (out_rnd),
    .out_bcast      (out_bcast)
);

// File: tb/req_sequencer_tb.sv
module req_sequencer_tb;
    localparam int IW = 8;
    localparam int VW = 32;

    typedef struct packed {
        logic [7:0] typ;
        logic       ld;
        logic [7:0] ldv;
        logic       drop;
        logic       ev;
        logic [7:0] et;
        logic [7:0] ei;
        logic       eb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 8'd0,   1'b0, 1'b1, 8'h03, 8'd0,   1'b1}, // R1 R3 first gets 0
        '{8'h00, 1'b0, 8'd0,   1'b0, 1'b1, 8'h03, 8'd1,   1'b1}, // R4
        '{8'h01, 1'b0, 8'd0,   1'b0, 1'b1, 8'h01, 8'hA5,  1'b0}, // R7
        '{8'h80, 1'b0, 8'd0,   1'b0, 1'b1, 8'h80, 8'hA5,  1'b0}, // R10
        '{8'h00, 1'b0, 8'd0,   1'b0, 1'b1, 8'h03, 8'd2,   1'b1}, // R7 counter held
        '{8'h04, 1'b0, 8'd0,   1'b1, 1'b0, 8'h00, 8'd0,   1'b0}, // R8
        '{8'h00, 1'b0, 8'd0,   1'b1, 1'b1, 8'h03, 8'd3,   1'b1}, // R8 counter held
        '{8'h02, 1'b1, 8'd50,  1'b1, 1'b0, 8'h00, 8'd0,   1'b0}, // R5 load alone
        '{8'h00, 1'b0, 8'd0,   1'b0, 1'b1, 8'h03, 8'd50,  1'b1}, // R5
        '{8'h00, 1'b1, 8'd100, 1'b0, 1'b1, 8'h03, 8'd100, 1'b1}, // R5 same cycle
        '{8'h00, 1'b0, 8'd0,   1'b0, 1'b1, 8'h03, 8'd101, 1'b1}, // R5 next
        '{8'h03, 1'b1, 8'd255, 1'b1, 1'b0, 8'h00, 8'd0,   1'b0}, // R6 setup
        '{8'h00, 1'b0, 8'd0,   1'b0, 1'b1, 8'h03, 8'd255, 1'b1}, // R6
        '{8'h00, 1'b0, 8'd0,   1'b0, 1'b1, 8'h03, 8'd0,   1'b1}  // R6 wrap
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_drop_other;
    logic [IW-1:0] cfg_limit, cfg_margin;
    logic          ld_en;
    logic [IW-1:0] ld_val;
    logic          in_valid, in_ready;
    logic [7:0]    in_type, in_rnd, in_vrnd;
    logic [IW-1:0] in_inst;
    logic [63:0]   in_sender;
    logic [VW-1:0] in_value;
    logic          out_valid, out_ready;
    logic [7:0]    out_type, out_rnd, out_vrnd;
    logic [IW-1:0] out_inst;
    logic [63:0]   out_sender;
    logic [VW-1:0] out_value;
    logic          out_bcast, near_limit;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    req_sequencer #(.IW(IW), .VW(VW)) u_dut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_drop_other = 1'b0; cfg_limit = 8'd200; cfg_margin = 8'd10;
        ld_en = 1'b0; ld_val = '0; in_valid = 1'b0; in_type = '0; in_inst = 8'hA5;
        in_rnd = 8'd9; in_vrnd = 8'd7; in_sender = 64'h0123_4567_89AB_CDEF;
        in_value = 32'hCAFE_F00D; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 in_ready", {63'd0, in_ready}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1; in_type = VEC[i].typ; ld_en = VEC[i].ld;
            ld_val = VEC[i].ldv; cfg_drop_other = VEC[i].drop;
            @(posedge clk);
            @(negedge clk);
            ld_en = 1'b0;
            check("R2 R8 valid", {63'd0, out_valid}, {63'd0, VEC[i].ev});
            if (VEC[i].ev) begin
                check("R3 R7 R10 type", {56'd0, out_type}, {56'd0, VEC[i].et});
                check("R3 R4 R5 R6 inst", {56'd0, out_inst}, {56'd0, VEC[i].ei});
                check("R3 R7 bcast", {63'd0, out_bcast}, {63'd0, VEC[i].eb});
                check("R3 rnd", {56'd0, out_rnd}, VEC[i].eb ? 64'd0 : 64'd9);
                check("R3 vrnd", {56'd0, out_vrnd}, 64'd7);
                check("R3 sender", out_sender, 64'h0123_4567_89AB_CDEF);
                check("R3 value", {32'd0, out_value}, 64'hCAFE_F00D);
            end
        end

        // R2 backpressure; counter now 1
        in_valid = 1'b0; cfg_drop_other = 1'b0;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b1; in_type = 8'h00; out_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 stalled valid", {63'd0, out_valid}, 64'd1);
        check("R2 stalled inst", {56'd0, out_inst}, 64'd1);
        check("R2 ready low", {63'd0, in_ready}, 64'd0);
        @(posedge clk); @(negedge clk);
        check("R2 held inst", {56'd0, out_inst}, 64'd1);
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R4 after stall", {56'd0, out_inst}, 64'd2);
        in_valid = 1'b0;

        // R9 near flag, limit 200 margin 10
        ld_en = 1'b1; ld_val = 8'd189;
        @(posedge clk); @(negedge clk);
        check("R9 far", {63'd0, near_limit}, 64'd0);
        ld_val = 8'd190;
        @(posedge clk); @(negedge clk);
        check("R9 edge", {63'd0, near_limit}, 64'd1);
        ld_val = 8'd201;
        @(posedge clk); @(negedge clk);
        check("R9 past", {63'd0, near_limit}, 64'd1);
        ld_en = 1'b0;

        // R1 reset again clears counter
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0; in_valid = 1'b1; in_type = 8'h00;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check("R1 reset count", {56'd0, out_inst}, 64'd0);
        finish_run();
    end
endmodule